// File: doc/BRIEF.md
# I2S Transmit Serializer With Format Options

This block turns stereo sample pairs into a serial audio bit stream. It runs on the system clock and takes two timing strobes from an external clock generator. `bitTick` is a one-cycle pulse at each inactive bit-clock edge, which is where the data line may change. `frameSync` goes high together with `bitTick` on the first bit period of a stereo frame, at the frame-clock change into the left slot. A frame holds two slots of `SLOT_BITS` bit periods each. The left slot comes first and the right slot second.

The block takes one sample pair per frame through a valid/ready handshake, exactly on the frame-start tick. Three static controls set the format:

- a two-bit word-length code;
- a first-bit delay flag that gives standard I2S timing, with the MSB one bit period after the frame-clock change;
- a right-justify flag that ends the sample on the last bit of its slot.

Each sample sits in the low-order bits of its input word and is sent MSB first. Every slot bit that carries no sample bit is driven to zero. If no pair is waiting at a frame start, the block sends a silent frame and pulses `underflow` for one cycle.

Top module: `i2sTxSerializer`

## Requirements
- R1: While `rstN` is low and after its release, `sdOut`, `underflow` and `inReady` are 0 until the first bit tick.
- R2: `wordLen` selects the sample width: code 0 means 16 bits, code 1 means 24 bits, code 2 means 32 bits, and code 3 behaves as 32 bits.
- R3: With `rightJust`=0 and `delayMode`=0, sample bit W-1 is sent on the first bit period of its slot, then the lower bits follow one per bit period (W is the width chosen by R2).
- R4: With `delayMode`=1 and `rightJust`=0, the whole output stream is the R3 stream delayed by exactly one bit period. With a full-width sample, the LSB of the right sample therefore appears on the first bit period of the next frame.
- R5: With `rightJust`=1, sample bit 0 is sent on the last bit period of its slot and bit W-1 on bit period SLOT_BITS-W. `delayMode` has no effect in this mode.
- R6: Slot bits outside the sample window are 0, and input bits at positions W and above are never sent.
- R7: Bit periods 0 to SLOT_BITS-1 of a frame carry `inLeft`, and bit periods SLOT_BITS to 2*SLOT_BITS-1 carry `inRight`.
- R8: `inReady` is 1 only in a cycle where `bitTick` and `frameSync` are both 1. The pair on `inLeft` and `inRight` is taken when `inValid` is also 1 in that cycle.
- R9: A frame-start tick without `inValid` makes `underflow` 1 for exactly the next cycle, and the frame sends only zeros. In delayed mode, the first bit of that frame is still the carried bit of the previous frame.
- R10: `sdOut` changes only in the cycle after a cycle in which `bitTick` is 1.
- R11: `frameSync` restarts the frame at bit period 0 whenever it arrives, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe at each inactive bit-clock edge |
| frameSync | input | 1 | Marks the tick that opens a frame (left slot) |
| wordLen | input | 2 | Sample width code (0:16, 1:24, 2 or 3:32) |
| delayMode | input | 1 | 1 = MSB one bit period after the frame-clock change |
| rightJust | input | 1 | 1 = sample ends on the last bit of its slot |
| inValid | input | 1 | A sample pair is offered |
| inReady | output | 1 | The pair is taken in this cycle |
| inLeft | input | SAMPLE_W | Left sample, right-aligned in the word |
| inRight | input | SAMPLE_W | Right sample, right-aligned in the word |
| sdOut | output | 1 | Serial data bit |
| underflow | output | 1 | One-cycle pulse when a frame starts with no pair |

## Verification
The assertions rely on four properties of the inputs:

- `frameSync` is asserted only together with `bitTick`;
- two frame-start ticks never fall in adjacent cycles;
- `bitTick` pulses are at least two cycles apart;
- the format controls change only on a frame-start tick.

The stimulus keeps to these. It raises `bitTick` for one cycle in every two and raises `frameSync` only on the tick for bit period 0. It applies a new format only in the same cycle as that tick, and always offers the pair before the frame-start edge so that the bypass path is exercised.

// File: rtl/i2sTxPkg.sv
`timescale 1ns/1ps
package i2sTxPkg;

  // Strobes passed from the frame control to the datapath
  typedef struct packed {
    logic tick;        // advance one bit period
    logic frameStart;  // this tick is bit period 0
    logic load;        // capture a new pair
    logic zeroFill;    // no pair: the frame is silent
    logic slotRight;   // current bit period is in the right slot
  } txStrobe_t;

  // Sample width from the two-bit code; code 3 behaves as 32
  function automatic logic [6:0] wordBits(input logic [1:0] code);
    case (code)
      2'd0:    wordBits = 7'd16;
      2'd1:    wordBits = 7'd24;
      default: wordBits = 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/i2sTxCtrl.sv
`timescale 1ns/1ps
module i2sTxCtrl
  import i2sTxPkg::*;
#(
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             frameSync,
  input  logic             inValid,
  output txStrobe_t        strb,
  output logic [POS_W-1:0] pos,
  output logic             inReady,
  output logic             underflow
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] SLOT_POS = POS_W'(SLOT_BITS);

  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] curPos;
  logic             frameTick;

  assign frameTick = bitTick & frameSync;
  assign curPos    = frameSync ? '0 : posCnt;
  assign pos       = curPos;
  assign inReady   = frameTick;

  always_comb begin
    strb.tick       = bitTick;
    strb.frameStart = frameTick;
    strb.load       = frameTick & inValid;
    strb.zeroFill   = frameTick & ~inValid;
    strb.slotRight  = (curPos >= SLOT_POS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt    <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= frameTick & ~inValid;
      if (bitTick)
        posCnt <= (curPos == LAST_POS) ? '0 : curPos + POS_W'(1);
    end
  end

  // R11
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    posCnt <= LAST_POS);

  // R11
  resync_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> posCnt == POS_W'(1));

  // R9
  underflow_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> !underflow);

endmodule

// File: rtl/i2sTxDatapath.sv
`timescale 1ns/1ps
module i2sTxDatapath
  import i2sTxPkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int IDX_W = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strb,
  input  logic [POS_W-1:0]    pos,
  input  logic [1:0]          wordLen,
  input  logic                delayMode,
  input  logic                rightJust,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                sdOut
);

  logic [SAMPLE_W-1:0] leftQ, rightQ;
  logic [SAMPLE_W-1:0] curLeft, curRight, curWord;
  logic [POS_W-1:0]    qPos;
  logic [6:0]          wBits;
  int unsigned         qI, wI;
  logic                hit;
  logic [IDX_W-1:0]    idxV;
  logic                newBit;
  logic                baseQ;
  logic                delayEff;

  assign delayEff = delayMode & ~rightJust;
  assign wBits    = wordBits(wordLen);

  // Bypass at frame start so the pair is used on the same tick it is taken
  assign curLeft  = strb.frameStart ? (strb.load ? inLeft  : '0) : leftQ;
  assign curRight = strb.frameStart ? (strb.load ? inRight : '0) : rightQ;
  assign curWord  = strb.slotRight ? curRight : curLeft;
  assign qPos     = strb.slotRight ? pos - POS_W'(SLOT_BITS) : pos;

  always_comb begin
    qI   = int'(qPos);
    wI   = (int'(wBits) > SAMPLE_W) ? SAMPLE_W : int'(wBits);
    hit  = 1'b0;
    idxV = '0;
    if (rightJust) begin
      if (qI + wI >= SLOT_BITS) begin
        hit  = 1'b1;
        idxV = IDX_W'(SLOT_BITS - 1 - qI);
      end
    end else if (qI < wI) begin
      hit  = 1'b1;
      idxV = IDX_W'(wI - 1 - qI);
    end
    newBit = hit & curWord[idxV];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ  <= '0;
      rightQ <= '0;
      baseQ  <= 1'b0;
      sdOut  <= 1'b0;
    end else begin
      if (strb.frameStart) begin
        leftQ  <= curLeft;
        rightQ <= curRight;
      end
      if (strb.tick) begin
        baseQ <= newBit;
        sdOut <= delayEff ? baseQ : newBit;
      end
    end
  end

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(sdOut));

  // R9
  silent_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroFill && !delayEff |=> !sdOut);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick && !rightJust && !delayEff && (qI >= wI) |=> !sdOut);

  // R5
  rj_lead_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick && rightJust && (qI + wI < SLOT_BITS) |=> !sdOut);

endmodule

// File: rtl/i2sTxSerializer.sv
`timescale 1ns/1ps
module i2sTxSerializer
  import i2sTxPkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int SLOT_BITS = 32,
  localparam int POS_W = $clog2(2 * SLOT_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                frameSync,
  input  logic [1:0]          wordLen,
  input  logic                delayMode,
  input  logic                rightJust,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                sdOut,
  output logic                underflow
);

  txStrobe_t        strb;
  logic [POS_W-1:0] pos;

  i2sTxCtrl #(.SLOT_BITS(SLOT_BITS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .frameSync (frameSync),
    .inValid   (inValid),
    .strb      (strb),
    .pos       (pos),
    .inReady   (inReady),
    .underflow (underflow)
  );

  i2sTxDatapath #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pos       (pos),
    .wordLen   (wordLen),
    .delayMode (delayMode),
    .rightJust (rightJust),
    .inLeft    (inLeft),
    .inRight   (inRight),
    .sdOut     (sdOut)
  );

endmodule

// File: tb/test_i2sTxSerializer.sv
`timescale 1ns/1ps
module test_i2sTxSerializer;

  localparam int SLOT = 32;
  localparam int FRAME = 2 * SLOT;
  localparam int NVEC = 10;

  // {wordLen, delayMode, rightJust, valid, left, right}
  localparam logic [68:0] VECS [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF_A5C3, 32'h0000_1234},
    {2'd1, 1'b0, 1'b0, 1'b1, 32'h00AB_CDEF, 32'hFF80_0001},
    {2'd2, 1'b0, 1'b0, 1'b1, 32'h8000_0001, 32'h7FFF_FFFE},
    {2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_8001, 32'h0000_C003},
    {2'd2, 1'b1, 1'b0, 1'b1, 32'h1234_5679, 32'h8765_4321},
    {2'd2, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'd0, 1'b1, 1'b1, 1'b1, 32'hABCD_F00D, 32'h0000_0001},
    {2'd1, 1'b0, 1'b1, 1'b1, 32'h00C0_FFEE, 32'h0000_0003},
    {2'd3, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0F0F_0F0F},
    {2'd0, 1'b0, 1'b0, 1'b0, 32'h1111_2222, 32'h3333_4444}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        bitTick, frameSync, inValid;
  logic [1:0]  wordLen;
  logic        delayMode, rightJust;
  logic [31:0] inLeft, inRight;
  logic        inReady, sdOut, underflow;

  int testCount = 0;
  int failCount = 0;
  logic prevBase = 1'b0;

  always #10 clk = ~clk;

  i2sTxSerializer i_i2sTxSerializer (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .wordLen(wordLen), .delayMode(delayMode), .rightJust(rightJust),
    .inValid(inValid), .inReady(inReady), .inLeft(inLeft), .inRight(inRight),
    .sdOut(sdOut), .underflow(underflow)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Slot image built from the requirements: the masked sample placed at the
  // top of the slot (R3) or at its bottom (R5), then read MSB first.
  function automatic logic expBase(input logic [1:0] wl, input logic rj,
                                   input logic valid, input logic [31:0] l,
                                   input logic [31:0] r, input int p);
    int w;
    logic [31:0] m, s, slotImg;
    w = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
    if (!valid) return 1'b0;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    s = ((p < SLOT) ? l : r) & m;
    slotImg = rj ? s : (s << (32 - w));
    return slotImg[31 - (p % SLOT)];
  endfunction

  function automatic string tagFor(input logic [1:0] wl, input logic dly,
                                   input logic rj, input logic valid, input int p);
    int w, q;
    w = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
    q = p % SLOT;
    if (!valid) return "R9";
    if (rj ? (q < SLOT - w) : (q >= w)) return "R6";
    if (wl == 2'd3) return "R2";
    if (rj) return "R5";
    if (dly) return "R4";
    if (p >= SLOT) return "R7";
    return "R3";
  endfunction

  task automatic runFrame(input logic [1:0] wl, input logic dly, input logic rj,
                          input logic valid, input logic [31:0] l,
                          input logic [31:0] r, input int nBits,
                          input string tagOverride);
    logic b, expOut;
    for (int p = 0; p < nBits; p++) begin
      @(negedge clk);
      bitTick = 1'b1;
      frameSync = (p == 0);
      if (p == 0) begin
        wordLen = wl; delayMode = dly; rightJust = rj;
        inValid = valid; inLeft = l; inRight = r;
      end else begin
        inValid = 1'b0;
      end
      #1;
      check("R8", inReady, (p == 0));
      @(negedge clk);
      bitTick = 1'b0;
      frameSync = 1'b0;
      inValid = 1'b0;
      b = expBase(wl, rj, valid, l, r, p);
      expOut = (dly && !rj) ? prevBase : b;
      prevBase = b;
      check((tagOverride != "") ? tagOverride : tagFor(wl, dly, rj, valid, p),
            sdOut, expOut);
      check("R9", underflow, (p == 0) && !valid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic hold;
    rstN = 1'b0; bitTick = 1'b0; frameSync = 1'b0; inValid = 1'b0;
    wordLen = 2'd0; delayMode = 1'b0; rightJust = 1'b0;
    inLeft = '0; inRight = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", sdOut, 1'b0);
    check("R1", underflow, 1'b0);
    check("R1", inReady, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", sdOut, 1'b0);

    // Table walk: one frame per vector
    for (int i = 0; i < NVEC; i++) begin
      runFrame(VECS[i][68:67], VECS[i][66], VECS[i][65], VECS[i][64],
               VECS[i][63:32], VECS[i][31:0], FRAME, "");
    end

    // R10: no ticks, output holds
    @(negedge clk);
    hold = sdOut;
    repeat (6) begin
      @(negedge clk);
      check("R10", sdOut, hold);
      check("R9", underflow, 1'b0);
    end

    // R11: frame cut short, then a new frame starts at bit period 0
    runFrame(2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_F0F0, 32'h0000_0F0F, 10, "R11");
    runFrame(2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_C0DE, 32'h0000_8421, FRAME, "R11");
    // R11 and R4: resync in delayed mode carries the cut-off bit
    runFrame(2'd2, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 20, "R11");
    runFrame(2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_0003, 32'hC000_0000, FRAME, "R4");

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule